// File: doc/BRIEF.md
# Steerable Tick-Based Watchdog

This block is a watchdog timer driven by an external 16 Hz tick strobe and controlled by one 8-bit control register. The register holds a timeout multiplier, a resolution exponent and a steering bit. From the multiplier and the resolution exponent the block computes a timeout, measured in tick periods of one sixteenth of a second. Software restarts the countdown by writing the register, or by reading it back. A write loads the new value. A read reloads the stored value.

If the countdown reaches its end before a restart, the block sets an expiry flag. The steering bit then selects the action. With steering set, the block issues a one-cycle system reset request, clears the control register and drops a persistent "no watchdog reset" status bit. With steering clear, it emits a one-cycle interrupt pulse and leaves the register as it is. After an expiry the counter stays idle until the next restart. The tick generator sits outside the block.

Top module: `wdg_steer_timer`

## Requirements
- R1: Control register layout: bits [1:0] hold the resolution exponent r, bits [6:2] hold the multiplier m, and bit 7 is the steering bit. After a restart the expiry happens on exactly the (m × 4^r)-th tick pulse.
- R2: A write strobe stores the write data in the control register and restarts the countdown from that new value. `rd_data` always shows the stored register value.
- R3: A read strobe restarts the countdown from the stored value and leaves the register unchanged.
- R4: When the multiplier field is zero the watchdog is disabled and never expires, whatever the resolution field holds. This includes the value 0x00.
- R5: Every restart clears `flags[7]`, and an expiry sets it. `flags[5:0]` always read zero.
- R6: An expiry with the steering bit set produces a `rst_req` pulse one clock long. In the same cycle the control register becomes 0x00 and `flags[6]` is cleared.
- R7: An expiry with the steering bit clear produces an `irq` pulse one clock long. The control register and `flags[6]` keep their values.
- R8: After an expiry, further ticks produce no action until a restart.
- R9: A restart strobe in the same cycle as the tick that would expire the count takes precedence. No expiry occurs, and the count reloads in full.
- R10: After reset, `rd_data` is 0x00, `flags` is 0x40, and `rst_req` and `irq` are low.
- R11: When the write and read strobes are both high in one cycle, the write data is stored and used for the restart.

Signals are registered as follows. The expiry outputs and flags change at the clock edge that samples the final tick. The register and flags change at the clock edge that samples a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle 16 Hz time-base strobe |
| wr_en | input | 1 | Control register write strobe (restarts the count) |
| wr_data | input | 8 | Control register write data |
| rd_en | input | 1 | Control register read strobe (restarts the count) |
| rd_data | output | 8 | Control register readback |
| flags | output | 8 | Bit 7 expiry flag, bit 6 persistent no-reset status |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A restart, from either a write or a read strobe, can land in the same clock cycle as the tick that would end the count. The bench provokes this case by programming a one-tick timeout and then raising the read strobe and the tick together. It then confirms three things: no reset or interrupt pulse appears, the expiry flag stays clear, and exactly one further tick is needed before the expiry fires. A second collision, a write strobe together with a read strobe, is judged by the stored value and by the timeout that follows.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   // action taken when the countdown ends
   typedef enum logic [1:0] {
      WDG_ACT_NONE  = 2'd0,
      WDG_ACT_IRQ   = 2'd1,
      WDG_ACT_RESET = 2'd2
   } wdg_act_e;

   // flag byte bit positions
   localparam int unsigned FLAG_EXPIRED = 7;
   localparam int unsigned FLAG_NOWDRST = 6;

   // load-value generator variants
   localparam int unsigned LOAD_SHIFT = 0;
   localparam int unsigned LOAD_MUX   = 1;
endpackage

// File: rtl/wdg_ctl_reg.sv
module wdg_ctl_reg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= wr_data;
      else if (clr)   q <= '0;
   end

   AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !wr_en) |=> (q == '0)); // R6
endmodule

// File: rtl/wdg_load_calc.sv
module wdg_load_calc #(
   parameter int unsigned MULT_W = 5,
   parameter int unsigned RES_W  = 2,
   parameter int unsigned CNT_W  = 11,
   parameter int unsigned STYLE  = 0
) (
   input  logic [MULT_W-1:0] mult,
   input  logic [RES_W-1:0]  res,
   output logic [CNT_W-1:0]  load
);
   localparam int unsigned N_RES = 2 ** RES_W;

   generate
      if (STYLE == wdg_pkg::LOAD_SHIFT) begin : g_shift
         assign load = CNT_W'(mult) << {res, 1'b0};
      end else begin : g_mux
         logic [CNT_W-1:0] opt [N_RES];
         for (genvar r = 0; r < N_RES; r++) begin : g_opt
            assign opt[r] = CNT_W'(mult) << (2 * r);
         end
         assign load = opt[res];
      end
   endgenerate

   always_comb begin
      AST_ZERO_MULT_ZERO_LOAD: assert ((mult != '0) || (load == '0)); // R4
   end
endmodule

// File: rtl/wdg_down_counter.sv
module wdg_down_counter #(
   parameter int unsigned CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] load,
   input  logic             tick,
   output logic             fire,
   output logic             active
);
   logic [CNT_W-1:0] cnt_q;

   assign fire = active & tick & (cnt_q == CNT_W'(1)) & ~restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         active <= 1'b0;
      end else if (restart) begin
         cnt_q  <= load;
         active <= (load != '0);
      end else if (fire) begin
         cnt_q  <= '0;
         active <= 1'b0;
      end else if (active && tick) begin
         cnt_q  <= cnt_q - CNT_W'(1);
      end
   end

   AST_ACTIVE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (cnt_q != '0)); // R1
   AST_FIRE_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !active); // R8
   AST_ZERO_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && load == '0) |=> !active); // R4
   AST_RESTART_BLOCKS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && load != '0) |=> (active && cnt_q == $past(load))); // R9
endmodule

// File: rtl/wdg_steer_timer.sv
module wdg_steer_timer #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned RES_W      = 2,
   parameter int unsigned MULT_W     = 5,
   parameter int unsigned LOAD_STYLE = wdg_pkg::LOAD_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] flags,
   output logic              rst_req,
   output logic              irq
);
   import wdg_pkg::*;

   localparam int unsigned CNT_W    = MULT_W + 2 * ((2 ** RES_W) - 1);
   localparam int unsigned MULT_LSB = RES_W;
   localparam int unsigned STEER_B  = DATA_W - 1;

   generate
      if (RES_W + MULT_W + 1 != DATA_W) begin : g_bad_fields
         $error("field widths must fill the control register");
      end
      if (DATA_W <= FLAG_EXPIRED) begin : g_bad_width
         $error("control register too narrow for flag byte");
      end
      if (LOAD_STYLE > LOAD_MUX) begin : g_bad_style
         $error("unknown load style");
      end
   endgenerate

   logic              restart;
   logic [DATA_W-1:0] ctl_q;
   logic [DATA_W-1:0] sel_val;
   logic [CNT_W-1:0]  load;
   logic              fire;
   logic              active;
   logic              clr_ctl;
   wdg_act_e          act;
   logic              exp_q;
   logic              keep_q;

   assign restart = wr_en | rd_en;
   assign sel_val = wr_en ? wr_data : ctl_q;

   always_comb begin
      act = WDG_ACT_NONE;
      if (fire) act = ctl_q[STEER_B] ? WDG_ACT_RESET : WDG_ACT_IRQ;
   end
   assign clr_ctl = (act == WDG_ACT_RESET);

   wdg_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .clr(clr_ctl), .q(ctl_q)
   );

   wdg_load_calc #(.MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W), .STYLE(LOAD_STYLE)) u_load (
      .mult(sel_val[MULT_LSB +: MULT_W]), .res(sel_val[RES_W-1:0]), .load(load)
   );

   wdg_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .restart(restart), .load(load), .tick(tick),
      .fire(fire), .active(active)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_q   <= 1'b0;
         keep_q  <= 1'b1;
         rst_req <= 1'b0;
         irq     <= 1'b0;
      end else begin
         rst_req <= (act == WDG_ACT_RESET);
         irq     <= (act == WDG_ACT_IRQ);
         if (restart)     exp_q <= 1'b0;
         else if (fire)   exp_q <= 1'b1;
         if (clr_ctl)     keep_q <= 1'b0;
      end
   end

   always_comb begin
      flags = '0;
      flags[FLAG_EXPIRED] = exp_q;
      flags[FLAG_NOWDRST] = keep_q;
   end
   assign rd_data = ctl_q;

   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_req && irq)); // R6
   AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R6
   AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (rd_data == '0 && !flags[FLAG_NOWDRST])); // R6
   AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R7
   AST_RESTART_CLR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !flags[FLAG_EXPIRED]); // R5
   AST_EXPIRY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req || irq) |-> flags[FLAG_EXPIRED]); // R5
   AST_LOW_FLAGS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      flags[5:0] == '0); // R5
   AST_READ_KEEPS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en) |=> (rd_data == $past(rd_data))); // R3
endmodule

// File: tb/test_wdg_steer_timer.sv
module test_wdg_steer_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic [7:0] flags;
   logic       rst_req;
   logic       irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic exp_keep = 1'b1;

   always #5 clk = ~clk;

   wdg_steer_timer i_wdg_steer_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .flags(flags), .rst_req(rst_req), .irq(irq)
   );

   // value written, expected tick count to expiry (0 = never)
   localparam int NV = 9;
   localparam logic [7:0] VEC_VAL [NV] = '{8'h04, 8'h05, 8'h28, 8'h0B, 8'h7E,
                                          8'h7F, 8'h03, 8'h86, 8'h00};
   localparam int VEC_TICKS [NV] = '{1, 4, 10, 128, 496, 1984, 0, 16, 0};
   localparam int NEVER_LIM = 2100;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   task automatic do_write(input logic [7:0] v);
      @(negedge clk); wr_en = 1'b1; wr_data = v;
      @(negedge clk); wr_en = 1'b0;
   endtask

   // one tick; returns 1 if a reset or interrupt pulse followed it
   task automatic one_tick(output logic hit, output logic was_rst);
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      hit = rst_req | irq;
      was_rst = rst_req;
   endtask

   initial begin
      logic hit, was_rst;
      int fired_at;
      logic fired_rst;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10", rd_data, 8'h00);
      chk("R10", flags, 8'h40);
      chk("R10", {rst_req, irq}, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         int lim;
         do_write(VEC_VAL[i]);
         chk("R2", rd_data, VEC_VAL[i]);
         chk("R5", flags[7], 0);
         lim = (VEC_TICKS[i] == 0) ? NEVER_LIM : VEC_TICKS[i] + 2;
         fired_at = 0;
         fired_rst = 1'b0;
         for (int k = 1; k <= lim; k++) begin
            one_tick(hit, was_rst);
            if (hit && fired_at == 0) begin
               fired_at = k;
               fired_rst = was_rst;
               // R5/R6/R7 state in the pulse cycle
               if (was_rst) begin
                  exp_keep = 1'b0;
                  chk("R6", rd_data, 8'h00);
               end else begin
                  chk("R7", rd_data, VEC_VAL[i]);
               end
               chk("R5", flags, {1'b1, exp_keep, 6'b0});
               @(negedge clk);
               chk("R6", rst_req, 0);
               chk("R7", irq, 0);
            end
         end
         if (VEC_TICKS[i] == 0) chk("R4", fired_at, 0);
         else begin
            chk("R1", fired_at, VEC_TICKS[i]);
            chk("R6", fired_rst, VEC_VAL[i][7]);
         end
         // R8 ticks beyond expiry (loop above already ran two extra)
         for (int k = 0; k < 3; k++) begin
            one_tick(hit, was_rst);
            chk("R8", hit, 0);
         end
      end

      // R3 read restarts with stored value
      do_write(8'h28);
      for (int k = 0; k < 7; k++) one_tick(hit, was_rst);
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      chk("R3", rd_data, 8'h28);
      fired_at = 0;
      for (int k = 1; k <= 12; k++) begin
         one_tick(hit, was_rst);
         if (hit && fired_at == 0) fired_at = k;
      end
      chk("R3", fired_at, 10);

      // R9 restart coincides with the expiring tick
      do_write(8'h04);
      @(negedge clk); tick = 1'b1; rd_en = 1'b1;
      @(negedge clk); tick = 1'b0; rd_en = 1'b0;
      chk("R9", {rst_req, irq}, 0);
      chk("R9", flags[7], 0);
      one_tick(hit, was_rst);
      chk("R9", hit, 1);
      chk("R9", flags[7], 1);

      // R11 write and read in the same cycle
      do_write(8'h28);
      @(negedge clk); wr_en = 1'b1; wr_data = 8'h04; rd_en = 1'b1;
      @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
      chk("R11", rd_data, 8'h04);
      one_tick(hit, was_rst);
      chk("R11", hit, 1);

      finish_run();
   end
endmodule